// File: doc/BRIEF.md
# Translation Context Qualifier and Fault Encoder

This block sits in front of an address translator. For each translation request it takes a 64-bit effective address, an access type (read, write or fetch) and the hypervisor mode bit. From the two top address bits (the quadrant) it picks which partition ID and process ID the translation will use. Each of the two IDs is either the value of the current ID register or zero. In guest mode two quadrants are forbidden, and a request that lands in one of them raises a segment-class fault instead of a context.

The same block also turns storage faults reported by the downstream translator into an interrupt class, an error code, a cause-register write and a fault-address-register write. All results are registered. Each one is marked by a valid pulse that lasts one cycle and comes one clock edge after the request or fault was presented.

Top module: `xlat_ctx_qualifier`

## Requirements
- R1: With `req_hv`=1, quadrant 0 (`req_ea[63:62]`=0) yields partition 0 with `cur_pid`, and quadrant 1 yields `cur_lpid` with `cur_pid`.
- R2: With `req_hv`=1, quadrant 2 yields `cur_lpid` with process 0, and quadrant 3 yields partition 0 with process 0.
- R3: With `req_hv`=0, quadrant 0 yields `cur_lpid` with `cur_pid`, and quadrant 3 yields `cur_lpid` with process 0.
- R4: With `req_hv`=0, quadrants 1 and 2 give no context (`ctx_valid` stays 0) and raise a segment fault (`exc_valid`=1).
- R5: A segment fault on a fetch (access code 2) reports class 1 (instruction segment), error code 0, and no fault-address or cause write.
- R6: A segment fault on a read (code 0) or write (code 1) reports class 2 (data segment), error code 0, `exc_far_we`=1 with `exc_far` equal to the request address, and no cause write.
- R7: A storage fault (`sf_valid`) on a fetch reports class 3 (instruction storage), with `sf_cause` as the error code and no fault-address or cause write.
- R8: A storage fault on a read or write reports class 4 (data storage), error code 0, `exc_far`=`sf_ea` with `exc_far_we`=1, and `exc_cause`=`sf_cause` with `exc_cause_we`=1. On a write, bit 25 of `exc_cause` is forced to 1.
- R9: Access code 3 is illegal. On either input it pulses `bad_req`, and it produces no context and no fault.
- R10: Every result shows up exactly one clock edge after its input and lasts one cycle. With no new input, all valids drop and `exc_class` returns to 0.
- R11: If a segment fault and a legal storage fault arrive in the same cycle, the segment fault is reported and the storage fault is dropped.
- R12: During and right after reset, `ctx_valid`, `exc_valid` and `bad_req` are 0 and `exc_class` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ea | input | 64 | Request effective address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| req_hv | input | 1 | Hypervisor mode bit |
| cur_lpid | input | 12 | Current partition ID register |
| cur_pid | input | 20 | Current process ID register |
| sf_valid | input | 1 | Storage fault from the translator |
| sf_acc | input | 2 | Access type of the faulting access |
| sf_ea | input | 64 | Effective address of the faulting access |
| sf_cause | input | 32 | Fault cause bits |
| ctx_valid | output | 1 | Context result pulse |
| ctx_lpid | output | 12 | Selected partition ID |
| ctx_pid | output | 20 | Selected process ID |
| exc_valid | output | 1 | Fault result pulse |
| exc_class | output | 3 | 0 none, 1 instr segment, 2 data segment, 3 instr storage, 4 data storage |
| exc_err_code | output | 32 | Error code |
| exc_cause | output | 32 | Value for the cause register |
| exc_cause_we | output | 1 | Cause register write |
| exc_far | output | 64 | Value for the fault-address register |
| exc_far_we | output | 1 | Fault-address register write |
| bad_req | output | 1 | Illegal access type pulse |

## Verification
Every result (context, fault fields and the illegal-request flag) comes from one register stage. A result is therefore due at the first rising edge after its stimulus and must be gone one edge later. The bench applies each stimulus at a falling edge, lets one rising edge pass, and reads the outputs at the following falling edge. It then removes the stimulus and, for the pulse checks, reads once more one cycle later to confirm that the valids have dropped.

// File: rtl/xq_pkg.sv
package xq_pkg;

  typedef enum logic [1:0] {
    ACC_RD    = 2'd0,
    ACC_WR    = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_BAD   = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_ISEG  = 3'd1,
    EXC_DSEG  = 3'd2,
    EXC_ISTOR = 3'd3,
    EXC_DSTOR = 3'd4
  } exc_e;

  // which of the two ID registers pass through, and whether the quadrant is allowed
  typedef struct packed {
    logic use_lpid;
    logic use_pid;
    logic legal;
  } ctx_sel_t;

  function automatic ctx_sel_t quad_decode(input logic hv, input logic [1:0] quad);
    ctx_sel_t s;
    if (hv) begin
      unique case (quad)
        2'd0:    s = '{use_lpid: 1'b0, use_pid: 1'b1, legal: 1'b1};
        2'd1:    s = '{use_lpid: 1'b1, use_pid: 1'b1, legal: 1'b1};
        2'd2:    s = '{use_lpid: 1'b1, use_pid: 1'b0, legal: 1'b1};
        default: s = '{use_lpid: 1'b0, use_pid: 1'b0, legal: 1'b1};
      endcase
    end else begin
      unique case (quad)
        2'd0:    s = '{use_lpid: 1'b1, use_pid: 1'b1, legal: 1'b1};
        2'd3:    s = '{use_lpid: 1'b1, use_pid: 1'b0, legal: 1'b1};
        default: s = '{use_lpid: 1'b0, use_pid: 1'b0, legal: 1'b0};
      endcase
    end
    return s;
  endfunction

  function automatic logic is_fetch(input logic [1:0] acc);
    return acc == ACC_FETCH;
  endfunction

endpackage

// File: rtl/xq_quadrant_sel.sv
module xq_quadrant_sel
  import xq_pkg::*;
#(
  parameter int EA_W   = 64,
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic [EA_W-1:0]   ea,
  input  logic              hv,
  input  logic [LPID_W-1:0] cur_lpid,
  input  logic [PID_W-1:0]  cur_pid,
  output logic [LPID_W-1:0] sel_lpid,
  output logic [PID_W-1:0]  sel_pid,
  output logic              seg_fault
);
  localparam int QHI = EA_W - 1;
  localparam int QLO = EA_W - 2;

  ctx_sel_t dec;

  always_comb begin
    dec       = quad_decode(hv, ea[QHI:QLO]);
    sel_lpid  = dec.use_lpid ? cur_lpid : '0;
    sel_pid   = dec.use_pid  ? cur_pid  : '0;
    seg_fault = !dec.legal;
  end
endmodule

// File: rtl/xq_fault_enc.sv
module xq_fault_enc
  import xq_pkg::*;
#(
  parameter int EA_W      = 64,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25
) (
  input  logic               seg_evt,
  input  logic [1:0]         seg_acc,
  input  logic [EA_W-1:0]    seg_ea,
  input  logic               stor_evt,
  input  logic [1:0]         stor_acc,
  input  logic [EA_W-1:0]    stor_ea,
  input  logic [CAUSE_W-1:0] stor_cause,
  output logic               evt,
  output exc_e               cls,
  output logic [CAUSE_W-1:0] err,
  output logic [CAUSE_W-1:0] cause,
  output logic               cause_we,
  output logic [EA_W-1:0]    far,
  output logic               far_we
);
  localparam logic [CAUSE_W-1:0] STORE_MASK = CAUSE_W'(1) << STORE_BIT;

  always_comb begin
    evt      = seg_evt || stor_evt;
    cls      = EXC_NONE;
    err      = '0;
    cause    = '0;
    cause_we = 1'b0;
    far      = '0;
    far_we   = 1'b0;
    if (seg_evt) begin
      if (is_fetch(seg_acc)) begin
        cls = EXC_ISEG;
      end else begin
        cls    = EXC_DSEG;
        far    = seg_ea;
        far_we = 1'b1;
      end
    end else if (stor_evt) begin
      if (is_fetch(stor_acc)) begin
        cls = EXC_ISTOR;
        err = stor_cause;
      end else begin
        cls      = EXC_DSTOR;
        cause    = (stor_acc == ACC_WR) ? (stor_cause | STORE_MASK) : stor_cause;
        cause_we = 1'b1;
        far      = stor_ea;
        far_we   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_ctx_qualifier.sv
module xlat_ctx_qualifier
  import xq_pkg::*;
#(
  parameter int EA_W      = 64,
  parameter int LPID_W    = 12,
  parameter int PID_W     = 20,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [EA_W-1:0]    req_ea,
  input  logic [1:0]         req_acc,
  input  logic               req_hv,
  input  logic [LPID_W-1:0]  cur_lpid,
  input  logic [PID_W-1:0]   cur_pid,
  input  logic               sf_valid,
  input  logic [1:0]         sf_acc,
  input  logic [EA_W-1:0]    sf_ea,
  input  logic [CAUSE_W-1:0] sf_cause,
  output logic               ctx_valid,
  output logic [LPID_W-1:0]  ctx_lpid,
  output logic [PID_W-1:0]   ctx_pid,
  output logic               exc_valid,
  output logic [2:0]         exc_class,
  output logic [CAUSE_W-1:0] exc_err_code,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic               exc_cause_we,
  output logic [EA_W-1:0]    exc_far,
  output logic               exc_far_we,
  output logic               bad_req
);
  // named internal events
  logic              req_acc_ok_w, sf_acc_ok_w;
  logic              seg_fault_w, seg_take_w, ctx_take_w, stor_take_w, bad_take_w;
  logic [LPID_W-1:0] sel_lpid_w;
  logic [PID_W-1:0]  sel_pid_w;
  logic              enc_evt_w, enc_cause_we_w, enc_far_we_w;
  exc_e              enc_cls_w;
  logic [CAUSE_W-1:0] enc_err_w, enc_cause_w;
  logic [EA_W-1:0]   enc_far_w;

  assign req_acc_ok_w = req_acc != ACC_BAD;
  assign sf_acc_ok_w  = sf_acc  != ACC_BAD;
  assign seg_take_w   = req_valid && req_acc_ok_w && seg_fault_w;
  assign ctx_take_w   = req_valid && req_acc_ok_w && !seg_fault_w;
  assign stor_take_w  = sf_valid && sf_acc_ok_w;
  assign bad_take_w   = (req_valid && !req_acc_ok_w) || (sf_valid && !sf_acc_ok_w);

  xq_quadrant_sel #(.EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W)) u_qsel (
    .ea       (req_ea),
    .hv       (req_hv),
    .cur_lpid (cur_lpid),
    .cur_pid  (cur_pid),
    .sel_lpid (sel_lpid_w),
    .sel_pid  (sel_pid_w),
    .seg_fault(seg_fault_w)
  );

  xq_fault_enc #(.EA_W(EA_W), .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT)) u_fenc (
    .seg_evt   (seg_take_w),
    .seg_acc   (req_acc),
    .seg_ea    (req_ea),
    .stor_evt  (stor_take_w),
    .stor_acc  (sf_acc),
    .stor_ea   (sf_ea),
    .stor_cause(sf_cause),
    .evt       (enc_evt_w),
    .cls       (enc_cls_w),
    .err       (enc_err_w),
    .cause     (enc_cause_w),
    .cause_we  (enc_cause_we_w),
    .far       (enc_far_w),
    .far_we    (enc_far_we_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_valid    <= 1'b0;
      ctx_lpid     <= '0;
      ctx_pid      <= '0;
      exc_valid    <= 1'b0;
      exc_class    <= EXC_NONE;
      exc_err_code <= '0;
      exc_cause    <= '0;
      exc_cause_we <= 1'b0;
      exc_far      <= '0;
      exc_far_we   <= 1'b0;
      bad_req      <= 1'b0;
    end else begin
      ctx_valid    <= ctx_take_w;
      if (ctx_take_w) begin
        ctx_lpid <= sel_lpid_w;
        ctx_pid  <= sel_pid_w;
      end
      exc_valid    <= enc_evt_w;
      exc_class    <= enc_cls_w;
      exc_err_code <= enc_err_w;
      exc_cause    <= enc_cause_w;
      exc_cause_we <= enc_cause_we_w;
      exc_far      <= enc_far_w;
      exc_far_we   <= enc_far_we_w;
      bad_req      <= bad_take_w;
    end
  end

  // guest quadrants 1 and 2 fault instead of producing a context
  p_guest_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_hv && req_acc_ok_w && (req_ea[EA_W-1] ^ req_ea[EA_W-2]))
      |=> (exc_valid && !ctx_valid));

  p_hv_always_ctx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_hv && req_acc_ok_w) |=> ctx_valid);

  p_iseg_no_far_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_take_w && req_acc == ACC_FETCH) |=> (exc_class == EXC_ISEG && !exc_far_we && exc_err_code == '0));

  p_dseg_far_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_take_w && req_acc != ACC_FETCH) |=> (exc_far_we && exc_far == $past(req_ea)));

  p_store_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stor_take_w && !seg_take_w && sf_acc == ACC_WR) |=> (exc_cause_we && exc_cause[STORE_BIT]));

  p_bad_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_acc == ACC_BAD && !sf_valid) |=> (bad_req && !ctx_valid && !exc_valid));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !sf_valid) |=> (!ctx_valid && !exc_valid && !bad_req));

  p_seg_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_take_w && stor_take_w) |=> (exc_class == EXC_ISEG || exc_class == EXC_DSEG));

endmodule

// File: tb/xlat_ctx_qualifier_tb.sv
module xlat_ctx_qualifier_tb_top;
  localparam int CLK_HALF = 4;  // 125 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_ea = '0;
  logic [1:0]  req_acc = '0;
  logic        req_hv = 1'b0;
  logic [11:0] cur_lpid = 12'hA5C;
  logic [19:0] cur_pid = 20'h31F2E;
  logic        sf_valid = 1'b0;
  logic [1:0]  sf_acc = '0;
  logic [63:0] sf_ea = '0;
  logic [31:0] sf_cause = '0;
  logic        ctx_valid, exc_valid, exc_cause_we, exc_far_we, bad_req;
  logic [11:0] ctx_lpid;
  logic [19:0] ctx_pid;
  logic [2:0]  exc_class;
  logic [31:0] exc_err_code, exc_cause;
  logic [63:0] exc_far;

  int vecs = 0;
  int miscompares = 0;

  always #(CLK_HALF) clk = ~clk;

  xlat_ctx_qualifier dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea), .req_acc(req_acc),
    .req_hv(req_hv), .cur_lpid(cur_lpid), .cur_pid(cur_pid), .sf_valid(sf_valid),
    .sf_acc(sf_acc), .sf_ea(sf_ea), .sf_cause(sf_cause), .ctx_valid(ctx_valid),
    .ctx_lpid(ctx_lpid), .ctx_pid(ctx_pid), .exc_valid(exc_valid), .exc_class(exc_class),
    .exc_err_code(exc_err_code), .exc_cause(exc_cause), .exc_cause_we(exc_cause_we),
    .exc_far(exc_far), .exc_far_we(exc_far_we), .bad_req(bad_req)
  );

  // {hv, acc[1:0], quad[1:0], kind[1:0] (0 ctx,1 seg,2 bad), lpid_cur, pid_cur}
  localparam logic [8:0] VECS [12] = '{
    9'b1_00_00_00_0_1, 9'b1_00_01_00_1_1, 9'b1_01_10_00_1_0, 9'b1_00_11_00_0_0,
    9'b0_00_00_00_1_1, 9'b0_00_01_01_0_0, 9'b0_01_10_01_0_0, 9'b0_00_11_00_1_0,
    9'b0_10_01_01_0_0, 9'b1_10_10_00_1_0, 9'b1_11_00_10_0_0, 9'b0_10_00_00_1_1
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle;
    req_valid = 1'b0;
    sf_valid  = 1'b0;
  endtask

  function automatic string ctx_tag(input logic hv, input logic [1:0] q);
    if (!hv) return "R3";
    return (q < 2) ? "R1" : "R2";
  endfunction

  initial begin
    #(2 * CLK_HALF * 20000);
    miscompares++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 ctx_valid in reset", 64'(ctx_valid), 64'd0);
    chk("R12 exc_valid in reset", 64'(exc_valid), 64'd0);
    rst_n = 1'b1;
    step();
    chk("R12 bad_req after reset", 64'(bad_req), 64'd0);
    chk("R12 exc_class after reset", 64'(exc_class), 64'd0);

    for (int i = 0; i < 12; i++) begin
      logic [8:0] v;
      logic [63:0] ea;
      v  = VECS[i];
      ea = {v[5:4], 30'h0, 32'h1000_0000 + 32'(i * 16'h0404)};
      @(negedge clk);
      req_valid = 1'b1; req_hv = v[8]; req_acc = v[7:6]; req_ea = ea;
      step();
      idle();
      case (v[3:2])
        2'd0: begin
          chk({ctx_tag(v[8], v[5:4]), " ctx_valid"}, 64'(ctx_valid), 64'd1);
          chk({ctx_tag(v[8], v[5:4]), " lpid"}, 64'(ctx_lpid), v[1] ? 64'(cur_lpid) : 64'd0);
          chk({ctx_tag(v[8], v[5:4]), " pid"}, 64'(ctx_pid), v[0] ? 64'(cur_pid) : 64'd0);
          chk({ctx_tag(v[8], v[5:4]), " no fault"}, 64'(exc_valid), 64'd0);
        end
        2'd1: begin
          chk("R4 no ctx", 64'(ctx_valid), 64'd0);
          chk("R4 exc_valid", 64'(exc_valid), 64'd1);
          if (v[7:6] == 2'd2) begin
            chk("R5 class", 64'(exc_class), 64'd1);
            chk("R5 far_we", 64'(exc_far_we), 64'd0);
            chk("R5 err", 64'(exc_err_code), 64'd0);
          end else begin
            chk("R6 class", 64'(exc_class), 64'd2);
            chk("R6 far_we", 64'(exc_far_we), 64'd1);
            chk("R6 far", exc_far, ea);
            chk("R6 cause_we", 64'(exc_cause_we), 64'd0);
          end
        end
        default: begin
          chk("R9 bad_req", 64'(bad_req), 64'd1);
          chk("R9 no ctx", 64'(ctx_valid), 64'd0);
          chk("R9 no exc", 64'(exc_valid), 64'd0);
        end
      endcase
    end

    // R10: pulse lasts one cycle
    step();
    chk("R10 ctx_valid dropped", 64'(ctx_valid), 64'd0);
    chk("R10 class back to none", 64'(exc_class), 64'd0);

    // R7: storage fault on fetch
    sf_valid = 1'b1; sf_acc = 2'd2; sf_ea = 64'h0000_7777_0000_1230; sf_cause = 32'h4000_0000;
    step(); idle();
    chk("R7 class", 64'(exc_class), 64'd3);
    chk("R7 err", 64'(exc_err_code), 64'h4000_0000);
    chk("R7 far_we", 64'(exc_far_we), 64'd0);
    chk("R7 cause_we", 64'(exc_cause_we), 64'd0);

    // R8: read storage fault, no store flag
    sf_valid = 1'b1; sf_acc = 2'd0; sf_ea = 64'hC000_0000_0ABC_0008; sf_cause = 32'h0800_0000;
    step(); idle();
    chk("R8 class", 64'(exc_class), 64'd4);
    chk("R8 read cause", 64'(exc_cause), 64'h0800_0000);
    chk("R8 far", exc_far, 64'hC000_0000_0ABC_0008);
    chk("R8 err", 64'(exc_err_code), 64'd0);

    // R8: write storage fault, store flag at bit 25
    sf_valid = 1'b1; sf_acc = 2'd1; sf_ea = 64'h0000_0000_0000_4444; sf_cause = 32'h0000_0010;
    step(); idle();
    chk("R8 write cause", 64'(exc_cause), 64'h0200_0010);
    chk("R8 cause_we", 64'(exc_cause_we), 64'd1);

    // R9: illegal access on the fault input
    sf_valid = 1'b1; sf_acc = 2'd3;
    step(); idle();
    chk("R9 sf bad_req", 64'(bad_req), 64'd1);
    chk("R9 sf no exc", 64'(exc_valid), 64'd0);

    // R11: same-cycle segment fault and storage fault
    req_valid = 1'b1; req_hv = 1'b0; req_acc = 2'd0; req_ea = 64'h4000_0000_0000_0100;
    sf_valid = 1'b1; sf_acc = 2'd2; sf_ea = 64'h1111; sf_cause = 32'h1;
    step(); idle();
    chk("R11 class", 64'(exc_class), 64'd2);
    chk("R11 far", exc_far, 64'h4000_0000_0000_0100);
    chk("R11 err", 64'(exc_err_code), 64'd0);
    step();
    chk("R10 exc_valid dropped", 64'(exc_valid), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miscompares);
    $finish;
  end
endmodule